// File: doc/BRIEF.md
# Header-Tagged Packet Fork and Merge

This block sits between a network-processor packet port and two downstream packet ports: a MAC port and a fabric port. All three use a 64-bit streaming bus with valid, ready, start-of-packet and end-of-packet. In the transmit direction, the first word of every packet from the processor is a routing header. The block reads that word, removes it, and forwards the rest of the packet to the port the header names. Start-of-packet is moved onto the first payload word.

In the receive direction, the block merges packets from the two ports into one stream toward the processor. Before each packet it writes a header word that tells which port the packet arrived on. The two ports share the stream round-robin, one whole packet at a time. Emitting the header costs one extra beat, so the port being served is held for one cycle at the start of each packet.

Two transmit faults are handled. A packet whose header matches neither legal value is dropped, and a sticky error flag is raised. A packet that carries a legal header and no payload is dropped and counted.

Top module: `pkt_fork_merge`

## Requirements
- R1: A transmit packet whose header word is 0x0000000000000000 has its payload delivered on the MAC egress port, in order. Nothing from it appears on the fabric egress port.
- R2: A transmit packet whose header word is 0x0000000100000000 has its payload delivered on the fabric egress port, in order. Nothing from it appears on the MAC egress port.
- R3: The header word is never forwarded. The egress port shows start-of-packet on the first payload word only, and end-of-packet on the same word where it arrived.
- R4: A transmit packet with any other header value is discarded up to and including its end-of-packet beat. `hdr_err` goes to 1 and stays there until reset.
- R5: A transmit packet that carries a legal header with end-of-packet on the header beat produces no egress beat. It increments `empty_drops` by exactly one.
- R6: While a transmit packet is being forwarded, `np_tx_ready` follows the ready of the chosen egress port. An egress beat offered but not accepted stays valid with unchanged data.
- R7: Each received packet reaches the processor side preceded by one header beat with start-of-packet set. That beat carries 0x0000000000000000 for the MAC port and 0x0000000100000000 for the fabric port. The payload follows with start-of-packet clear and end-of-packet unchanged.
- R8: Packets from the two ingress ports are never interleaved. When both ports hold a waiting packet, grants alternate by packet, and the MAC port wins first after reset.
- R9: During the header beat, neither ingress port is ready. During the payload, only the granted port is ready, and only while `np_rx_ready` is high.
- R10: During and right after reset, no valid is asserted on any output bus, `hdr_err` is 0 and `empty_drops` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| np_tx_data | input | 64 | Transmit word from the processor |
| np_tx_sop | input | 1 | Transmit start of packet (header beat) |
| np_tx_eop | input | 1 | Transmit end of packet |
| np_tx_valid | input | 1 | Transmit word valid |
| np_tx_ready | output | 1 | Block accepts the transmit word |
| mac_tx_data | output | 64 | MAC egress word |
| mac_tx_sop | output | 1 | MAC egress start of packet |
| mac_tx_eop | output | 1 | MAC egress end of packet |
| mac_tx_valid | output | 1 | MAC egress valid |
| mac_tx_ready | input | 1 | MAC egress ready |
| fab_tx_data | output | 64 | Fabric egress word |
| fab_tx_sop | output | 1 | Fabric egress start of packet |
| fab_tx_eop | output | 1 | Fabric egress end of packet |
| fab_tx_valid | output | 1 | Fabric egress valid |
| fab_tx_ready | input | 1 | Fabric egress ready |
| hdr_err | output | 1 | Sticky flag: an illegal transmit header was seen |
| empty_drops | output | 16 | Count of header-only transmit packets dropped |
| mac_rx_data | input | 64 | MAC ingress word |
| mac_rx_sop | input | 1 | MAC ingress start of packet |
| mac_rx_eop | input | 1 | MAC ingress end of packet |
| mac_rx_valid | input | 1 | MAC ingress valid |
| mac_rx_ready | output | 1 | Block accepts the MAC ingress word |
| fab_rx_data | input | 64 | Fabric ingress word |
| fab_rx_sop | input | 1 | Fabric ingress start of packet |
| fab_rx_eop | input | 1 | Fabric ingress end of packet |
| fab_rx_valid | input | 1 | Fabric ingress valid |
| fab_rx_ready | output | 1 | Block accepts the fabric ingress word |
| np_rx_data | output | 64 | Merged word to the processor |
| np_rx_sop | output | 1 | Merged start of packet (header beat) |
| np_rx_eop | output | 1 | Merged end of packet |
| np_rx_valid | output | 1 | Merged word valid |
| np_rx_ready | input | 1 | Processor accepts the merged word |

## Verification
Some properties are checked on every cycle:
- the two egress valids are never high together;
- the error flag is sticky;
- the drop counter moves by at most one per cycle;
- every merged start-of-packet beat carries one of the two legal headers, while both ingress ports are held;
- a stalled merged beat stays put.

Other behaviour only the bench scenarios can show, because it spans whole packets:
- the payload order and the relocation of start-of-packet onto the first payload word;
- that a bad packet leaves no trace on either egress;
- the strict packet-by-packet alternation of the merge when both ports are busy;
- that no packet's payload is cut into another's.

// File: rtl/pkt_fork_merge.sv
module pkt_fork_merge #(
  parameter int DW    = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    np_tx_data,
  input  logic             np_tx_sop,
  input  logic             np_tx_eop,
  input  logic             np_tx_valid,
  output logic             np_tx_ready,
  output logic [DW-1:0]    mac_tx_data,
  output logic             mac_tx_sop,
  output logic             mac_tx_eop,
  output logic             mac_tx_valid,
  input  logic             mac_tx_ready,
  output logic [DW-1:0]    fab_tx_data,
  output logic             fab_tx_sop,
  output logic             fab_tx_eop,
  output logic             fab_tx_valid,
  input  logic             fab_tx_ready,
  output logic             hdr_err,
  output logic [CNT_W-1:0] empty_drops,
  input  logic [DW-1:0]    mac_rx_data,
  input  logic             mac_rx_sop,
  input  logic             mac_rx_eop,
  input  logic             mac_rx_valid,
  output logic             mac_rx_ready,
  input  logic [DW-1:0]    fab_rx_data,
  input  logic             fab_rx_sop,
  input  logic             fab_rx_eop,
  input  logic             fab_rx_valid,
  output logic             fab_rx_ready,
  output logic [DW-1:0]    np_rx_data,
  output logic             np_rx_sop,
  output logic             np_rx_eop,
  output logic             np_rx_valid,
  input  logic             np_rx_ready
);
  localparam logic [DW-1:0] HDR_MAC = '0;
  localparam logic [DW-1:0] HDR_FAB = DW'(64'h0000_0001_0000_0000);

  typedef enum logic [1:0] {T_HDR, T_FWD, T_DROP} tx_st_t;
  typedef enum logic [1:0] {R_IDLE, R_HDR, R_BODY} rx_st_t;

  // transmit fork
  tx_st_t tx_st;
  logic   t_fab, t_first;

  wire t_fwd   = (tx_st == T_FWD);
  wire tx_go   = np_tx_valid & np_tx_ready;
  wire hdr_mac = (np_tx_data == HDR_MAC);
  wire hdr_fab = (np_tx_data == HDR_FAB);

  assign mac_tx_data  = np_tx_data;
  assign fab_tx_data  = np_tx_data;
  assign mac_tx_sop   = t_first;
  assign fab_tx_sop   = t_first;
  assign mac_tx_eop   = np_tx_eop;
  assign fab_tx_eop   = np_tx_eop;
  assign mac_tx_valid = t_fwd & ~t_fab & np_tx_valid;
  assign fab_tx_valid = t_fwd &  t_fab & np_tx_valid;
  assign np_tx_ready  = t_fwd ? (t_fab ? fab_tx_ready : mac_tx_ready) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_st       <= T_HDR;
      t_fab       <= 1'b0;
      t_first     <= 1'b0;
      hdr_err     <= 1'b0;
      empty_drops <= '0;
    end else begin
      case (tx_st)
        T_HDR: if (tx_go && np_tx_sop) begin
          if (hdr_mac || hdr_fab) begin
            if (np_tx_eop) empty_drops <= empty_drops + 1'b1;
            else begin
              tx_st   <= T_FWD;
              t_fab   <= hdr_fab;
              t_first <= 1'b1;
            end
          end else begin
            hdr_err <= 1'b1;
            if (!np_tx_eop) tx_st <= T_DROP;
          end
        end
        T_FWD: if (tx_go) begin
          t_first <= 1'b0;
          if (np_tx_eop) tx_st <= T_HDR;
        end
        T_DROP: if (tx_go && np_tx_eop) tx_st <= T_HDR;
        default: tx_st <= T_HDR;
      endcase
    end
  end

  // receive merge
  rx_st_t rx_st;
  logic   r_fab, r_last;

  wire req_m    = mac_rx_valid & mac_rx_sop;
  wire req_f    = fab_rx_valid & fab_rx_sop;
  wire pick_fab = req_f & (~req_m | ~r_last);
  wire r_idle   = (rx_st == R_IDLE);
  wire r_body   = (rx_st == R_BODY);
  wire hdr_port = r_idle ? pick_fab : r_fab;
  wire offer    = (r_idle & (req_m | req_f)) | (rx_st == R_HDR);

  assign np_rx_valid  = offer | (r_body & (r_fab ? fab_rx_valid : mac_rx_valid));
  assign np_rx_data   = r_body ? (r_fab ? fab_rx_data : mac_rx_data)
                               : (hdr_port ? HDR_FAB : HDR_MAC);
  assign np_rx_sop    = ~r_body;
  assign np_rx_eop    = r_body & (r_fab ? fab_rx_eop : mac_rx_eop);
  assign mac_rx_ready = r_body ? (~r_fab & np_rx_ready) : (r_idle & mac_rx_valid & ~mac_rx_sop);
  assign fab_rx_ready = r_body ? ( r_fab & np_rx_ready) : (r_idle & fab_rx_valid & ~fab_rx_sop);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_st  <= R_IDLE;
      r_fab  <= 1'b0;
      r_last <= 1'b1;
    end else begin
      case (rx_st)
        R_IDLE: if (req_m || req_f) begin
          r_fab <= pick_fab;
          rx_st <= np_rx_ready ? R_BODY : R_HDR;
        end
        R_HDR: if (np_rx_ready) rx_st <= R_BODY;
        R_BODY: if (np_rx_valid && np_rx_ready && np_rx_eop) begin
          r_last <= r_fab;
          rx_st  <= R_IDLE;
        end
        default: rx_st <= R_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_fork_merge_chk.sv
module pkt_fork_merge_chk #(
  parameter int DW    = 64,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             np_tx_valid,
  input logic             np_tx_ready,
  input logic             mac_tx_valid,
  input logic             mac_tx_ready,
  input logic             fab_tx_valid,
  input logic             fab_tx_ready,
  input logic             hdr_err,
  input logic [CNT_W-1:0] empty_drops,
  input logic             mac_rx_ready,
  input logic             fab_rx_ready,
  input logic [DW-1:0]    np_rx_data,
  input logic             np_rx_sop,
  input logic             np_rx_valid,
  input logic             np_rx_ready
);
  localparam logic [DW-1:0] HDR_FAB = DW'(64'h0000_0001_0000_0000);

  assert_single_egress_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mac_tx_valid, fab_tx_valid}));

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> hdr_err);

  assert_drop_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(empty_drops - $past(empty_drops)) <= CNT_W'(1));

  assert_tx_backpressure_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (np_tx_valid && np_tx_ready && (mac_tx_valid || fab_tx_valid))
      |-> (mac_tx_valid ? mac_tx_ready : fab_tx_ready));

  assert_rx_header_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (np_rx_valid && np_rx_sop) |-> (np_rx_data == '0 || np_rx_data == HDR_FAB));

  assert_header_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (np_rx_valid && np_rx_sop) |-> (!mac_rx_ready && !fab_rx_ready));

  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (np_rx_valid && !np_rx_ready) |=> (np_rx_valid && $stable(np_rx_data)));
endmodule

bind pkt_fork_merge pkt_fork_merge_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/pkt_fork_merge_test.sv
module pkt_fork_merge_test;
  localparam logic [63:0] HF = 64'h0000_0001_0000_0000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [63:0] np_tx_data = '0; logic np_tx_sop = 0, np_tx_eop = 0, np_tx_valid = 0; logic np_tx_ready;
  logic [63:0] mac_tx_data; logic mac_tx_sop, mac_tx_eop, mac_tx_valid; logic mac_tx_ready = 1;
  logic [63:0] fab_tx_data; logic fab_tx_sop, fab_tx_eop, fab_tx_valid; logic fab_tx_ready = 1;
  logic hdr_err; logic [15:0] empty_drops;
  logic [63:0] mac_rx_data = '0; logic mac_rx_sop = 0, mac_rx_eop = 0, mac_rx_valid = 0; logic mac_rx_ready;
  logic [63:0] fab_rx_data = '0; logic fab_rx_sop = 0, fab_rx_eop = 0, fab_rx_valid = 0; logic fab_rx_ready;
  logic [63:0] np_rx_data; logic np_rx_sop, np_rx_eop, np_rx_valid; logic np_rx_ready = 1;

  pkt_fork_merge uut (.*);

  int total = 0, bad = 0;
  bit tx_rand = 0, rx_rand = 0;
  int exp_cnt = 0; bit exp_err = 0;
  logic [65:0] exp_mac[$], exp_fab[$], got_mac[$], got_fab[$];
  logic [65:0] rxq_m[$], rxq_f[$];
  int hdr_seq[$];
  int cur = -1;

  task automatic check(bit ok, string req, logic [65:0] act, logic [65:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word(int port, int pkt, int i);
    return {8'(8'hA0 + port), 8'h00, 16'(pkt), 32'(i)};
  endfunction

  // sink readiness
  initial forever begin
    @(negedge clk);
    mac_tx_ready = tx_rand ? ($urandom % 3 != 0) : 1'b1;
    fab_tx_ready = tx_rand ? ($urandom % 3 != 0) : 1'b1;
    np_rx_ready  = rx_rand ? ($urandom % 3 != 0) : 1'b1;
  end

  // egress monitor with hold check (R6)
  initial begin
    bit pm = 0, pf = 0; logic [63:0] dm = '0, df = '0;
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (pm) check(mac_tx_valid && mac_tx_data == dm, "R6", {1'b0, mac_tx_valid, mac_tx_data}, {2'b01, dm});
        if (pf) check(fab_tx_valid && fab_tx_data == df, "R6", {1'b0, fab_tx_valid, fab_tx_data}, {2'b01, df});
        if (mac_tx_valid && mac_tx_ready) got_mac.push_back({mac_tx_sop, mac_tx_eop, mac_tx_data});
        if (fab_tx_valid && fab_tx_ready) got_fab.push_back({fab_tx_sop, fab_tx_eop, fab_tx_data});
        pm = mac_tx_valid && !mac_tx_ready; dm = mac_tx_data;
        pf = fab_tx_valid && !fab_tx_ready; df = fab_tx_data;
      end else begin
        pm = 0; pf = 0;
      end
    end
  end

  // merged stream monitor
  initial forever begin
    logic [65:0] e;
    @(negedge clk); #2;
    if (rst_n && np_rx_valid && !np_rx_ready)
      check(!mac_rx_ready && !fab_rx_ready, "R9", {mac_rx_ready, fab_rx_ready}, 0);
    if (rst_n && np_rx_valid && np_rx_ready) begin
      if (np_rx_sop) begin
        check(np_rx_data == 64'h0 || np_rx_data == HF, "R7", np_rx_data, HF);
        check(!mac_rx_ready && !fab_rx_ready, "R9", {mac_rx_ready, fab_rx_ready}, 0);
        check(cur == -1, "R8", cur, 66'h3ffff_ffff_ffff_ffff);
        cur = (np_rx_data == HF) ? 1 : 0;
        hdr_seq.push_back(cur);
      end else if (cur == -1) begin
        check(0, "R8", {np_rx_eop, np_rx_data}, 0);
      end else begin
        if (cur == 1 && rxq_f.size() > 0) e = rxq_f.pop_front();
        else if (cur == 0 && rxq_m.size() > 0) e = rxq_m.pop_front();
        else e = '1;
        check({np_rx_sop, np_rx_eop, np_rx_data} == e, "R7", {np_rx_sop, np_rx_eop, np_rx_data}, e);
        check((cur ? fab_rx_ready : mac_rx_ready) && !(cur ? mac_rx_ready : fab_rx_ready),
              "R9", {mac_rx_ready, fab_rx_ready}, cur ? 1 : 2);
        if (np_rx_eop) cur = -1;
      end
    end
  end

  task automatic tx_beat(logic [63:0] d, bit s, bit e);
    @(negedge clk);
    np_tx_valid = 1; np_tx_data = d; np_tx_sop = s; np_tx_eop = e;
    #1;
    while (!np_tx_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic tx_idle();
    @(negedge clk); np_tx_valid = 0; np_tx_sop = 0; np_tx_eop = 0;
  endtask

  // kind 0: MAC, 1: fabric, 2: illegal header
  task automatic send_tx(int kind, int len, int id);
    logic [63:0] h;
    h = (kind == 0) ? 64'h0 : (kind == 1) ? HF : (64'hDEAD_0000_0000_0000 + 64'(id));
    tx_beat(h, 1, len == 0);
    for (int i = 0; i < len; i++) begin
      tx_beat(word(kind, id, i), 0, i == len - 1);
      if (kind == 0) exp_mac.push_back({i == 0, i == len - 1, word(kind, id, i)});
      if (kind == 1) exp_fab.push_back({i == 0, i == len - 1, word(kind, id, i)});
    end
    if (kind < 2 && len == 0) exp_cnt++;
    if (kind == 2) exp_err = 1;
    tx_idle();
  endtask

  task automatic rx_beat(int port, logic [63:0] d, bit s, bit e);
    @(negedge clk);
    if (port == 1) begin fab_rx_valid = 1; fab_rx_data = d; fab_rx_sop = s; fab_rx_eop = e; end
    else begin mac_rx_valid = 1; mac_rx_data = d; mac_rx_sop = s; mac_rx_eop = e; end
    #1;
    while (!(port == 1 ? fab_rx_ready : mac_rx_ready)) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic rx_idle(int port);
    @(negedge clk);
    if (port == 1) begin fab_rx_valid = 0; fab_rx_sop = 0; end
    else begin mac_rx_valid = 0; mac_rx_sop = 0; end
  endtask

  task automatic rx_stream(int port, int n, int base, bit gaps);
    for (int p = 0; p < n; p++) begin
      int len = 1 + ($urandom % 4);
      for (int i = 0; i < len; i++) begin
        if (port == 1) rxq_f.push_back({1'b0, i == len - 1, word(port + 4, base + p, i)});
        else rxq_m.push_back({1'b0, i == len - 1, word(port + 4, base + p, i)});
      end
      for (int i = 0; i < len; i++) rx_beat(port, word(port + 4, base + p, i), i == 0, i == len - 1);
      if (gaps) begin
        rx_idle(port);
        repeat ($urandom % 3) @(negedge clk);
      end
    end
    rx_idle(port);
  endtask

  task automatic compare_tx();
    repeat (4) @(negedge clk);
    check(got_mac.size() == exp_mac.size(), "R1", got_mac.size(), exp_mac.size());
    check(got_fab.size() == exp_fab.size(), "R2", got_fab.size(), exp_fab.size());
    while (got_mac.size() > 0 && exp_mac.size() > 0) begin
      logic [65:0] a = got_mac.pop_front(), e = exp_mac.pop_front();
      check(a == e, "R1/R3", a, e);
    end
    while (got_fab.size() > 0 && exp_fab.size() > 0) begin
      logic [65:0] a = got_fab.pop_front(), e = exp_fab.pop_front();
      check(a == e, "R2/R3", a, e);
    end
    got_mac.delete(); got_fab.delete(); exp_mac.delete(); exp_fab.delete();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=done");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd8675309));
    repeat (3) @(negedge clk);
    #2;
    check(!mac_tx_valid && !fab_tx_valid && !np_rx_valid, "R10",
          {mac_tx_valid, fab_tx_valid, np_rx_valid}, 0);
    check(!hdr_err && empty_drops == 0, "R10", {hdr_err, empty_drops}, 0);
    @(negedge clk); rst_n = 1;
    #2;
    check(!mac_tx_valid && !fab_tx_valid && !np_rx_valid && !hdr_err && empty_drops == 0, "R10",
          {mac_tx_valid, fab_tx_valid, np_rx_valid, hdr_err, empty_drops}, 0);

    // directed transmit cases
    send_tx(0, 3, 1);
    send_tx(1, 1, 2);
    send_tx(0, 2, 3);
    @(negedge clk); #2;
    check(!hdr_err && empty_drops == 0, "R4", {hdr_err, empty_drops}, 0);
    compare_tx();
    send_tx(0, 0, 4);
    @(negedge clk); #2;
    check(empty_drops == 16'(exp_cnt), "R5", empty_drops, exp_cnt);
    send_tx(1, 0, 5);
    send_tx(2, 3, 6);
    send_tx(1, 2, 7);
    send_tx(2, 0, 8);
    @(negedge clk); #2;
    check(hdr_err == 1'b1, "R4", hdr_err, 1);
    check(empty_drops == 16'(exp_cnt), "R5", empty_drops, exp_cnt);
    compare_tx();

    // random transmit traffic with egress backpressure
    tx_rand = 1;
    for (int k = 0; k < 60; k++) begin
      int r = $urandom % 20;
      send_tx(r < 9 ? 0 : (r < 18 ? 1 : 2), $urandom % 6, 100 + k);
    end
    tx_rand = 0;
    compare_tx();
    @(negedge clk); #2;
    check(hdr_err == exp_err, "R4", hdr_err, exp_err);
    check(empty_drops == 16'(exp_cnt), "R5", empty_drops, exp_cnt);

    // receive merge: both ports loaded at once, no backpressure
    hdr_seq.delete();
    fork
      rx_stream(0, 4, 0, 0);
      rx_stream(1, 4, 0, 0);
    join
    repeat (4) @(negedge clk);
    check(hdr_seq.size() == 8, "R8", hdr_seq.size(), 8);
    foreach (hdr_seq[k]) check(hdr_seq[k] == (k % 2), "R8", hdr_seq[k], k % 2);
    check(rxq_m.size() == 0 && rxq_f.size() == 0, "R7", rxq_m.size() + rxq_f.size(), 0);

    // random merge traffic with processor backpressure
    rx_rand = 1;
    fork
      rx_stream(0, 12, 50, 1);
      rx_stream(1, 12, 50, 1);
    join
    rx_rand = 0;
    repeat (6) @(negedge clk);
    check(rxq_m.size() == 0 && rxq_f.size() == 0, "R7", rxq_m.size() + rxq_f.size(), 0);
    check(cur == -1, "R8", cur, 66'h3ffff_ffff_ffff_ffff);

    // reset clears the sticky flag and the counter
    @(negedge clk); rst_n = 0;
    @(negedge clk); #2;
    check(!hdr_err && empty_drops == 0 && !np_rx_valid, "R10", {hdr_err, empty_drops}, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk); #2;
    check(!hdr_err, "R4", hdr_err, 0);

    summary();
    $finish;
  end
endmodule